// File: doc/BRIEF.md
# Fused Multiply-Add Exceptional Result Resolver

This combinational unit sits beside the arithmetic datapath of a double-precision fused multiply-add. It takes the three operands of `z + x*y` (or `z - x*y` when the negate-product control is set), decodes the class of each one, and decides whether the result is fixed by the exceptional-value rules. Those cases are NaN propagation, infinite products, invalid infinity arithmetic and signed-zero sums. When it decides the result, it raises a valid flag, drives the 64-bit result and reports whether the invalid-operation exception applies.

When the valid flag is low, every operand is an ordinary finite value and the product is nonzero. The downstream multiplier, adder and rounder then own the result, and this unit's result and invalid outputs are held at zero. The rounding mode matters only for the sign of an exact zero sum.

Top module: `fma_special_resolver`

## Requirements
- R1: When any operand is a signaling NaN (exponent all ones, fraction nonzero, fraction MSB clear), the result is the first signaling NaN in the order z, x, y. It is returned with its fraction MSB set, and `spec_invalid` is high.
- R2: When no operand is a signaling NaN but at least one is a quiet NaN (exponent all ones, fraction MSB set), the result is the first quiet NaN in the order z, x, y, returned bit for bit. `spec_invalid` is low.
- R3: When the operands are NaN-free and one factor is infinite while the other is a zero of either sign, the result is the default NaN 64'h7FF8000000000000 and `spec_invalid` is high.
- R4: The product sign is the XOR of the signs of x and y, inverted when `neg_prod` is 1.
- R5: When the product is infinite and z is an infinity of the opposite sign to the product, the result is the default NaN and `spec_invalid` is high. Otherwise the result is an infinity with the product sign, and `spec_invalid` is low.
- R6: When the product is finite and z is infinite, the result equals z.
- R7: When the product is zero and z is a zero of the same sign, the result is z. When the signs differ, the result is +0, or -0 when `rnd_mode` is 2'b11 (round toward minus infinity).
- R8: When the product is zero and z is a nonzero finite value (normal or subnormal), the result equals z.
- R9: When x and y are both nonzero finite values and z is finite, `spec_valid` is low.
- R10: Whenever `spec_valid` is low, `spec_result` and `spec_invalid` are zero. Every exceptional case above drives `spec_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_z | input | 64 | Addend operand, IEEE double |
| op_x | input | 64 | First factor, IEEE double |
| op_y | input | 64 | Second factor, IEEE double |
| neg_prod | input | 1 | 1 subtracts the product instead of adding it |
| rnd_mode | input | 2 | Rounding mode; 2'b11 is round toward minus infinity |
| spec_valid | output | 1 | The result is decided here |
| spec_result | output | 64 | Exceptional result, zero when not valid |
| spec_invalid | output | 1 | Invalid-operation exception |

## Verification
The unit has no registers, so each result is due in the same cycle that its operands are applied. The driver changes the inputs just after a rising edge and pushes the expected triple into a queue. The monitor pops that triple at the following falling edge and compares it with the outputs, which have had half a period to settle. Each entry is therefore checked exactly once, before the next stimulus arrives.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;

    localparam int WORD_W = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = WORD_W - EXP_W - 1;
    localparam int NUM_OPS = 3;

    typedef enum logic [2:0] {
        FC_ZERO,
        FC_SUB,
        FC_NORM,
        FC_INF,
        FC_QNAN,
        FC_SNAN
    } fp_class_e;

    typedef struct packed {
        logic              sign;
        fp_class_e         cls;
        logic [WORD_W-1:0] bits;
    } fp_opnd_t;

    typedef struct packed {
        logic              hit;
        logic              invalid;
        logic [WORD_W-1:0] value;
    } spec_out_t;

    function automatic fp_class_e classify(input logic [WORD_W-1:0] w);
        logic [EXP_W-1:0]  e;
        logic [FRAC_W-1:0] f;
        e = w[WORD_W-2 -: EXP_W];
        f = w[FRAC_W-1:0];
        if (e == '0)
            return (f == '0) ? FC_ZERO : FC_SUB;
        else if (e == '1) begin
            if (f == '0)
                return FC_INF;
            return f[FRAC_W-1] ? FC_QNAN : FC_SNAN;
        end
        return FC_NORM;
    endfunction

    function automatic logic [WORD_W-1:0] quieten(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] q;
        q = w;
        q[FRAC_W-1] = 1'b1;
        return q;
    endfunction

    function automatic logic [WORD_W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] make_zero(input logic s);
        return {s, {(WORD_W-1){1'b0}}};
    endfunction

    function automatic logic is_finite_nz(input fp_class_e c);
        return (c == FC_SUB) || (c == FC_NORM);
    endfunction

endpackage

// File: rtl/fsr_classify.sv
module fsr_classify
    import fma_sc_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    output fp_opnd_t          opnd_out
);
    always_comb begin
        opnd_out.sign = word_in[WORD_W-1];
        opnd_out.cls  = classify(word_in);
        opnd_out.bits = word_in;
    end
endmodule

// File: rtl/fsr_nan_select.sv
module fsr_nan_select
    import fma_sc_pkg::*;
(
    input  fp_opnd_t  ops [NUM_OPS],
    output spec_out_t nan_out
);
    logic [NUM_OPS-1:0] is_snan;
    logic [NUM_OPS-1:0] is_qnan;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_flag
        assign is_snan[i] = (ops[i].cls == FC_SNAN);
        assign is_qnan[i] = (ops[i].cls == FC_QNAN);
    end

    always_comb begin
        nan_out = '0;
        // quiet NaNs first so that a signaling NaN overrides them;
        // within each kind scan from last to first so index 0 wins
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (is_qnan[i] && (is_snan == '0)) begin
                nan_out.hit     = 1'b1;
                nan_out.invalid = 1'b0;
                nan_out.value   = ops[i].bits;
            end
        end
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (is_snan[i]) begin
                nan_out.hit     = 1'b1;
                nan_out.invalid = 1'b1;
                nan_out.value   = quieten(ops[i].bits);
            end
        end
    end
endmodule

// File: rtl/fsr_value_rules.sv
module fsr_value_rules
    import fma_sc_pkg::*;
#(
    parameter logic [WORD_W-1:0] DEFAULT_NAN  = 64'h7FF8_0000_0000_0000,
    parameter logic [1:0]        RM_DOWN_CODE = 2'b11
) (
    input  fp_opnd_t   opnd_z,
    input  fp_opnd_t   opnd_x,
    input  fp_opnd_t   opnd_y,
    input  logic       negate,
    input  logic [1:0] rmode,
    output spec_out_t  rule_out
);
    logic prod_sign;
    logic x_inf, y_inf, x_zero, y_zero, z_inf, z_zero;

    always_comb begin
        prod_sign = opnd_x.sign ^ opnd_y.sign ^ negate;
        x_inf  = (opnd_x.cls == FC_INF);
        y_inf  = (opnd_y.cls == FC_INF);
        x_zero = (opnd_x.cls == FC_ZERO);
        y_zero = (opnd_y.cls == FC_ZERO);
        z_inf  = (opnd_z.cls == FC_INF);
        z_zero = (opnd_z.cls == FC_ZERO);

        rule_out = '0;
        if ((x_inf && y_zero) || (x_zero && y_inf)) begin
            rule_out.hit     = 1'b1;
            rule_out.invalid = 1'b1;
            rule_out.value   = DEFAULT_NAN;
        end else if (x_inf || y_inf) begin
            rule_out.hit = 1'b1;
            if (z_inf && (opnd_z.sign != prod_sign)) begin
                rule_out.invalid = 1'b1;
                rule_out.value   = DEFAULT_NAN;
            end else begin
                rule_out.value = make_inf(prod_sign);
            end
        end else if (z_inf) begin
            rule_out.hit   = 1'b1;
            rule_out.value = opnd_z.bits;
        end else if (x_zero || y_zero) begin
            rule_out.hit = 1'b1;
            if (z_zero && (opnd_z.sign != prod_sign))
                rule_out.value = make_zero(rmode == RM_DOWN_CODE);
            else
                rule_out.value = opnd_z.bits;
        end
    end
endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_sc_pkg::*;
#(
    parameter logic [WORD_W-1:0] DEFAULT_NAN  = 64'h7FF8_0000_0000_0000,
    parameter logic [1:0]        RM_DOWN_CODE = 2'b11
) (
    input  logic [63:0] op_z,
    input  logic [63:0] op_x,
    input  logic [63:0] op_y,
    input  logic        neg_prod,
    input  logic [1:0]  rnd_mode,
    output logic        spec_valid,
    output logic [63:0] spec_result,
    output logic        spec_invalid
);
    logic [WORD_W-1:0] raw_ops [NUM_OPS];
    fp_opnd_t          opnds   [NUM_OPS];
    spec_out_t         nan_res;
    spec_out_t         rule_res;
    spec_out_t         final_res;

    // index order sets NaN priority: z, x, y
    assign raw_ops[0] = op_z;
    assign raw_ops[1] = op_x;
    assign raw_ops[2] = op_y;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
        fsr_classify u_cls (
            .word_in  (raw_ops[i]),
            .opnd_out (opnds[i])
        );
    end

    fsr_nan_select u_nan (
        .ops     (opnds),
        .nan_out (nan_res)
    );

    fsr_value_rules #(
        .DEFAULT_NAN  (DEFAULT_NAN),
        .RM_DOWN_CODE (RM_DOWN_CODE)
    ) u_rules (
        .opnd_z   (opnds[0]),
        .opnd_x   (opnds[1]),
        .opnd_y   (opnds[2]),
        .negate   (neg_prod),
        .rmode    (rnd_mode),
        .rule_out (rule_res)
    );

    assign final_res = nan_res.hit ? nan_res : rule_res;

    assign spec_valid   = final_res.hit;
    assign spec_result  = final_res.value;
    assign spec_invalid = final_res.invalid;
endmodule

// File: rtl/fma_special_resolver_checker.sv
module fma_special_resolver_checker (
    input logic [63:0] op_z,
    input logic [63:0] op_x,
    input logic [63:0] op_y,
    input logic        neg_prod,
    input logic [1:0]  rnd_mode,
    input logic        spec_valid,
    input logic [63:0] spec_result,
    input logic        spec_invalid
);
    function automatic logic chk_nan(input logic [63:0] w);
        return (w[62:52] == 11'h7FF) && (w[51:0] != 52'd0);
    endfunction
    function automatic logic chk_inf(input logic [63:0] w);
        return (w[62:52] == 11'h7FF) && (w[51:0] == 52'd0);
    endfunction
    function automatic logic chk_zero(input logic [63:0] w);
        return w[62:0] == 63'd0;
    endfunction

    logic any_nan, all_fin, factors_nz;

    always_comb begin
        any_nan    = chk_nan(op_z) || chk_nan(op_x) || chk_nan(op_y);
        all_fin    = (op_z[62:52] != 11'h7FF) && (op_x[62:52] != 11'h7FF)
                     && (op_y[62:52] != 11'h7FF);
        factors_nz = !chk_zero(op_x) && !chk_zero(op_y);

        // R10
        a_r10_idle_outputs_zero: assert (spec_valid || (spec_result == 64'd0 && !spec_invalid))
            else $error("R10: idle outputs not zero");
        // R1 / R2
        a_r1_nan_in_nan_out: assert (!any_nan || (spec_valid && chk_nan(spec_result)))
            else $error("R1: NaN operand did not yield NaN");
        // R3 / R5
        a_r3_invalid_is_nan: assert (!spec_invalid || chk_nan(spec_result))
            else $error("R3: invalid raised with non-NaN result");
        // R9
        a_r9_ordinary_not_special: assert (!(all_fin && factors_nz) || !spec_valid)
            else $error("R9: ordinary operands flagged special");
        // R6
        a_r6_inf_addend_passes: assert (!(chk_inf(op_z) && !any_nan
                                          && op_x[62:52] != 11'h7FF && op_y[62:52] != 11'h7FF)
                                        || (spec_valid && spec_result == op_z && !spec_invalid))
            else $error("R6: infinite addend not passed through");
    end
endmodule

bind fma_special_resolver fma_special_resolver_checker u_chk (
    .op_z         (op_z),
    .op_x         (op_x),
    .op_y         (op_y),
    .neg_prod     (neg_prod),
    .rnd_mode     (rnd_mode),
    .spec_valid   (spec_valid),
    .spec_result  (spec_result),
    .spec_invalid (spec_invalid)
);

// File: tb/fma_special_resolver_bench.sv
module fma_special_resolver_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] TWO    = 64'h4000_0000_0000_0000;
    localparam logic [63:0] M_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] TINY   = 64'h0000_0000_0000_0001;
    localparam logic [63:0] QN_A   = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] QN_B   = 64'h7FF8_0000_0000_0002;
    localparam logic [63:0] SN_A   = 64'h7FF0_0000_0000_0005;
    localparam logic [63:0] SN_AQ  = 64'h7FF8_0000_0000_0005;
    localparam logic [63:0] SN_B   = 64'hFFF0_0000_0000_0007;
    localparam logic [63:0] SN_BQ  = 64'hFFF8_0000_0000_0007;
    localparam logic [63:0] DNAN   = 64'h7FF8_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_z = '0, op_x = '0, op_y = '0;
    logic        neg_prod = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        spec_valid;
    logic [63:0] spec_result;
    logic        spec_invalid;

    typedef struct {
        logic        v;
        logic [63:0] r;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_resolver u_fma_special_resolver (
        .op_z         (op_z),
        .op_x         (op_x),
        .op_y         (op_y),
        .neg_prod     (neg_prod),
        .rnd_mode     (rnd_mode),
        .spec_valid   (spec_valid),
        .spec_result  (spec_result),
        .spec_invalid (spec_invalid)
    );

    task automatic drive(input logic [63:0] z, input logic [63:0] x, input logic [63:0] y,
                         input logic neg, input logic [1:0] rm,
                         input logic ev, input logic [63:0] er, input logic einv,
                         input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        op_z = z; op_x = x; op_y = y; neg_prod = neg; rnd_mode = rm;
        e.v = ev; e.r = er; e.inv = einv; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: result is due in the same cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (spec_valid !== e.v || spec_result !== e.r || spec_invalid !== e.inv) begin
                errors++;
                $display("FAIL %s: got v=%0b r=%h inv=%0b, expected v=%0b r=%h inv=%0b",
                         e.tag, spec_valid, spec_result, spec_invalid, e.v, e.r, e.inv);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: all-zero operands give +0 + (+0)*(+0) = +0 (R7, R10)
        drive(P_ZERO, P_ZERO, P_ZERO, 0, 2'b00, 1, P_ZERO, 0, "R7 idle zeros");
        // R1 signaling NaN priority and quieting
        drive(QN_A, SN_B, ONE, 0, 2'b00, 1, SN_BQ, 1, "R1 sNaN x beats qNaN z");
        drive(SN_A, SN_B, ONE, 0, 2'b00, 1, SN_AQ, 1, "R1 sNaN z beats sNaN x");
        drive(QN_A, ONE, SN_A, 0, 2'b00, 1, SN_AQ, 1, "R1 sNaN y beats qNaN z");
        // R2 quiet NaN priority
        drive(ONE, QN_A, QN_B, 0, 2'b00, 1, QN_A, 0, "R2 qNaN x before y");
        drive(QN_B, QN_A, P_INF, 0, 2'b00, 1, QN_B, 0, "R2 qNaN z first");
        drive(P_ZERO, P_INF, QN_B, 0, 2'b00, 1, QN_B, 0, "R2 qNaN y over inf*zero");
        // R3 inf times zero
        drive(ONE, P_INF, P_ZERO, 0, 2'b00, 1, DNAN, 1, "R3 inf*0");
        drive(ONE, N_ZERO, N_INF, 1, 2'b00, 1, DNAN, 1, "R3 -0*-inf");
        // R4 / R5 infinite product
        drive(N_INF, P_INF, TWO, 0, 2'b00, 1, DNAN, 1, "R5 +inf + -inf");
        drive(N_INF, P_INF, TWO, 1, 2'b00, 1, N_INF, 0, "R4 negated product matches -inf");
        drive(ONE, N_INF, ONE, 0, 2'b00, 1, N_INF, 0, "R4 product sign negative");
        drive(N_INF, N_INF, M_ONE, 1, 2'b00, 1, N_INF, 0, "R4 double negative then negated");
        drive(P_INF, TINY, P_INF, 0, 2'b00, 1, P_INF, 0, "R5 same-sign infinities");
        // R6 finite product, infinite z
        drive(N_INF, ONE, TWO, 0, 2'b00, 1, N_INF, 0, "R6 z -inf");
        drive(P_INF, P_ZERO, TWO, 1, 2'b00, 1, P_INF, 0, "R6 zero product z +inf");
        // R7 signed zero sums
        drive(N_ZERO, P_ZERO, TINY, 0, 2'b00, 1, P_ZERO, 0, "R7 opposite zeros nearest");
        drive(N_ZERO, P_ZERO, TINY, 0, 2'b11, 1, N_ZERO, 0, "R7 opposite zeros round-down");
        drive(N_ZERO, N_ZERO, ONE, 0, 2'b00, 1, N_ZERO, 0, "R7 same sign -0");
        drive(N_ZERO, P_ZERO, ONE, 1, 2'b00, 1, N_ZERO, 0, "R7 negated product same sign");
        drive(P_ZERO, P_ZERO, ONE, 1, 2'b11, 1, N_ZERO, 0, "R7 negated opposite round-down");
        drive(P_ZERO, P_ZERO, ONE, 0, 2'b11, 1, P_ZERO, 0, "R7 same sign +0 round-down");
        // R8 zero product, nonzero finite z
        drive(M_ONE, P_ZERO, TWO, 0, 2'b00, 1, M_ONE, 0, "R8 z -1");
        drive(TINY, TINY, N_ZERO, 1, 2'b11, 1, TINY, 0, "R8 z subnormal");
        // R9 / R10 ordinary operands
        drive(ONE, ONE, TWO, 0, 2'b00, 0, 64'd0, 0, "R9 normal operands");
        drive(P_ZERO, TINY, TINY, 1, 2'b11, 0, 64'd0, 0, "R10 subnormal factors, zero z");
        drive(M_ONE, TWO, M_ONE, 0, 2'b01, 0, 64'd0, 0, "R9 mixed signs");
        @(posedge clk);
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule